// File: doc/BRIEF.md
# Headset Key Press Poller

This block finds out whether the send/end key of a 4-pole headset is pressed. The key sits on the microphone pole, so it cannot be watched all the time. The poller closes the microphone path switch for a short sensing window at the start of every polling period. On the last millisecond tick inside that window it takes one sample from an external threshold comparator, where a high comparator bit means the key is pressed. A debounce stage then accepts a new key state only after that state has been seen in enough back-to-back samples to cover the required persistence time. It drives a registered key flag in which 1 means pressed.

Polling runs only while the detection controller reports an accessory that is both plugged in and classified as 4-pole. If either of those flags drops, polling stops in the next cycle and the key flag clears at once. A host enable input keeps the switch closed all the time so the microphone path can be used. Polling and debounce continue in the background while that enable is high. The analog comparator and the switch itself sit outside this block.

Top module: `key_poller`

## Requirements
- R1: After reset, key_out is 0 and sw_close is 0 while host_en is low.
- R2: While plugged and four_pole are both 1 and host_en is 0, sw_close is 1 for the first WIN_MS ticks of every PER_MS-tick period and 0 for the rest. The first period starts in the cycle the accessory becomes active.
- R3: cmp_hit is sampled only on the last tick of each sensing window. Its value at any other time has no effect on key_out.
- R4: key_out goes from 0 to 1 only after DEB_N consecutive samples are 1. DEB_N = ceil(DEB_MS/PER_MS)+1, which is 4 with the defaults, so the samples span at least DEB_MS ticks.
- R5: key_out goes from 1 to 0 only after DEB_N consecutive samples are 0.
- R6: A sample equal to the current key_out restarts the run of samples that must agree.
- R7: When plugged or four_pole is 0, key_out is 0 from the next cycle and polling restarts from the start of a period when the accessory is active again.
- R8: While host_en is 1, sw_close is 1 in every cycle. Polling and debounce carry on unchanged.
- R9: key_out is 1 for a pressed key (cmp_hit 1 when sampled) and 0 for no press.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_1ms | input | 1 | One-cycle pulse once per millisecond |
| plugged | input | 1 | Accessory present, from the detection controller |
| four_pole | input | 1 | Accessory classified as 4-pole |
| host_en | input | 1 | Host request to hold the microphone switch closed |
| cmp_hit | input | 1 | Comparator output, 1 when the key is pressed |
| sw_close | output | 1 | Microphone switch control, 1 closes the switch |
| key_out | output | 1 | Debounced key state, 1 when pressed |

## Verification
sw_close is combinational from the inputs and the phase count. It is therefore due in the same cycle as a change of host_en or of the accessory flags, and one cycle after the tick that moves the phase. key_out is registered. It changes in the cycle after the sampling tick that completes a debounce run, and one cycle after the accessory is lost. The bench drives inputs on the falling edge and compares both outputs against a behavioural model on every clock, one time unit after the inputs settle. Directed checks are placed after whole polling periods, when the count of samples is known.

// File: rtl/key_poller.sv
module key_poller #(
  parameter int WIN_MS = 1,
  parameter int PER_MS = 10,
  parameter int DEB_MS = 27
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_1ms,
  input  logic plugged,
  input  logic four_pole,
  input  logic host_en,
  input  logic cmp_hit,
  output logic sw_close,
  output logic key_out
);
  localparam int DEB_N = (DEB_MS + PER_MS - 1) / PER_MS + 1;
  localparam int PW = (PER_MS > 1) ? $clog2(PER_MS) : 1;
  localparam int CW = $clog2(DEB_N + 1);

  logic          active;
  logic          in_win;
  logic          smp;
  logic [PW-1:0] ph;
  logic [CW-1:0] run;
  logic          key_q;

  assign active   = plugged & four_pole;
  assign in_win   = active && (ph < PW'(WIN_MS));
  assign smp      = active && tick_1ms && (ph == PW'(WIN_MS - 1));
  assign sw_close = host_en | in_win;
  assign key_out  = key_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph    <= '0;
      run   <= '0;
      key_q <= 1'b0;
    end else if (!active) begin
      ph    <= '0;
      run   <= '0;
      key_q <= 1'b0;
    end else begin
      if (tick_1ms)
        ph <= (ph == PW'(PER_MS - 1)) ? '0 : ph + 1'b1;
      if (smp) begin
        if (cmp_hit != key_q) begin
          if (run == CW'(DEB_N - 1)) begin
            key_q <= cmp_hit;
            run   <= '0;
          end else begin
            run <= run + 1'b1;
          end
        end else begin
          run <= '0;
        end
      end
    end
  end
endmodule

// File: rtl/key_poller_chk.sv
module key_poller_chk (
  input logic clk,
  input logic rst_n,
  input logic tick_1ms,
  input logic plugged,
  input logic four_pole,
  input logic host_en,
  input logic cmp_hit,
  input logic sw_close,
  input logic key_out
);
  // R1
  key_reset_chk: assert property (@(posedge clk) $rose(rst_n) |-> !key_out);
  // R7
  drop_clears_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(plugged && four_pole) |=> !key_out);
  // R2
  idle_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!host_en && !(plugged && four_pole)) |-> !sw_close);
  // R8
  host_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    host_en |-> sw_close);
  // R3
  key_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(key_out) && $past(plugged && four_pole)) |-> $past(tick_1ms));
  // R9
  rise_on_press_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(key_out) |-> $past(cmp_hit));
  // R5
  fall_on_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(key_out) && $past(plugged && four_pole)) |-> !$past(cmp_hit));
endmodule

bind key_poller key_poller_chk chk_i (
  .clk(clk), .rst_n(rst_n), .tick_1ms(tick_1ms), .plugged(plugged),
  .four_pole(four_pole), .host_en(host_en), .cmp_hit(cmp_hit),
  .sw_close(sw_close), .key_out(key_out)
);

// File: tb/key_poller_tb_top.sv
`timescale 1ns/1ps
module key_poller_tb_top;
  localparam int WIN = 1, PER = 10, DEB = 27;
  localparam int NEED = (DEB + PER - 1) / PER + 1;
  localparam int TCLK = 5;

  logic clk = 0, rst_n = 0, tick = 0, plugged = 0, fourp = 0, hen = 0, cmp = 0;
  logic sw_close, key_out;
  int   tests = 0, fails = 0;
  bit   done = 0;

  key_poller #(.WIN_MS(WIN), .PER_MS(PER), .DEB_MS(DEB)) dut_i (
    .clk(clk), .rst_n(rst_n), .tick_1ms(tick), .plugged(plugged),
    .four_pole(fourp), .host_en(hen), .cmp_hit(cmp),
    .sw_close(sw_close), .key_out(key_out));

  always #5 clk = ~clk;

  int m_ms = 0, m_run = 0;
  bit m_key = 0;
  always @(posedge clk) begin
    if (!rst_n || !(plugged && fourp)) begin
      m_ms = 0; m_run = 0; m_key = 0;
    end else if (tick) begin
      if (m_ms == WIN - 1) begin
        if (cmp != m_key) begin
          m_run++;
          if (m_run == NEED) begin m_key = cmp; m_run = 0; end
        end else m_run = 0;
      end
      m_ms = (m_ms + 1) % PER;
    end
  end

  task automatic chk(input string tag, input logic act, input logic exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b @%0t", tag, act, exp, $time);
    end
  endtask

  // every clock: sw_close (R2 R8) and key_out (R4 R5 R6) against the model
  task automatic cyc(input bit t);
    @(negedge clk);
    tick = t;
    #1;
    chk("R2 R8 sw_close model", sw_close, hen || (plugged && fourp && m_ms < WIN));
    chk("R4 R5 R6 key_out model", key_out, m_key);
  endtask

  task automatic one_tick(input bit c);
    cmp = c;
    cyc(1);
    for (int i = 1; i < TCLK; i++) cyc(0);
  endtask

  task automatic period(input bit c_smp, input bit c_other);
    one_tick(c_smp);
    for (int i = 1; i < PER; i++) one_tick(c_other);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk("R1 key after reset", key_out, 0);
    chk("R1 switch after reset", sw_close, 0);
    rst_n = 1;
    cyc(0);
    plugged = 1; fourp = 1;
    #1; chk("R2 window opens on activation", sw_close, 1);
    for (int p = 0; p < NEED - 1; p++) period(1, 0);
    chk("R4 no press before full run", key_out, 0);
    one_tick(1);
    chk("R4 R9 press after full run", key_out, 1);
    cyc(0);
    #1; chk("R2 window closed mid period", sw_close, 0);
    for (int i = 1; i < PER; i++) one_tick(0);
    for (int p = 0; p < NEED - 1; p++) period(0, 1);
    period(1, 1);
    chk("R6 agreeing sample restarts run", key_out, 1);
    for (int p = 0; p < NEED - 1; p++) period(0, 1);
    chk("R3 off-window highs ignored", key_out, 1);
    period(0, 1);
    chk("R5 release after full run", key_out, 0);
    hen = 1;
    period(0, 0);
    chk("R8 switch held by host", sw_close, 1);
    for (int p = 0; p < NEED; p++) period(1, 0);
    chk("R8 polling continues with host enable", key_out, 1);
    hen = 0;
    plugged = 0;
    cyc(0);
    chk("R7 unplug clears key", key_out, 0);
    chk("R7 switch open after unplug", sw_close, 0);
    plugged = 1; fourp = 0;
    for (int p = 0; p < NEED + 1; p++) period(1, 1);
    chk("R7 3-pole never polls", key_out, 0);
    fourp = 1;
    #1; chk("R7 window restarts on reactivation", sw_close, 1);
    for (int p = 0; p < NEED; p++) period(1, 0);
    chk("R9 press seen again", key_out, 1);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule